// File: doc/BRIEF.md
# Serial Overhead Byte Insertion Port

This block takes a byte-wide transmit frame stream, tagged with row and column numbers, and overwrites a fixed set of 19 transport overhead bytes with values that an external device supplies over a slow three-wire serial link. The block produces the serial clock and a strobe that marks the start of a request. It then shifts in 152 bits and stores them in a shadow buffer. At the next frame start it copies the shadow buffer into the active buffer, so a frame is never substituted from a partly loaded set.

The transmit stream uses valid/ready. The block holds no data in the stream path: `m_valid` follows `s_valid`, `s_ready` follows `m_ready`, and `m_data` is formed combinationally from the current input beat. A beat moves when `s_valid` and `m_ready` are both high. A stalled beat has no effect on the position tracking. A global insertion switch and a per-byte enable vector decide which bytes are replaced.

A transferred beat whose row/column is not the successor of the previous transferred beat is a position jump. If a capture is in progress, the jump abandons it and discards its bits. A new request starts after the next frame start.

Top module: `oh_serial_insert`

## Requirements
- R1: `oh_sclk` has a period of DIV clock cycles and is high for the first DIV/2 cycles of each period (DIV even, default 360).
- R2: `oh_strobe` rises only together with a rising edge of `oh_sclk` and stays high for exactly one serial period. A request is issued only after a frame-start beat (row 0, column 0) has transferred.
- R3: After the strobe period, one bit is taken from `oh_sdata` at the end of each of the next 152 serial periods, MSB first. Byte slots in arrival order are k=0..18: J0, E1, F1, D1, D2, D3, K1, K2, D4 … D12, S1, E2. Bit k of `byte_enable` belongs to slot k.
- R4: Overhead columns are 0 to 2, and slots sit at (row, column): J0 (0,2); E1 (1,1); F1 (1,2); D1–D3 (2,0..2); K1 (4,1); K2 (4,2); D4–D12 (rows 5 to 7, columns 0..2 in row-major order); S1 (8,0); E2 (8,2).
- R5: A fully received set replaces the active set when the next frame-start beat transfers. All later substitutions use the new set.
- R6: A slot byte is replaced only when `ins_enable` is 1, its `byte_enable` bit is 1 and a set has been committed since reset. Otherwise `m_data` equals `s_data`.
- R7: Positions outside the 19 slots pass unchanged. This covers A1, A2, B1, B2, H1–H3, M1 and every column from 3 upward.
- R8: A position jump during a strobe or shift phase abandons that capture, and its bytes are never used. A new strobe follows after the next frame start.
- R9: `m_valid` equals `s_valid` and `s_ready` equals `m_ready` in the same cycle. Only transferred beats advance the expected position.
- R10: During reset `oh_strobe` is low and no set is loaded, so the stream passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| ins_enable | input | 1 | Global insertion switch |
| byte_enable | input | 19 | Per-slot insertion enable, bit k = slot k |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with s_valid |
| s_data | input | 8 | Input frame byte |
| s_row | input | 4 | Row of the input byte, 0..8 |
| s_col | input | $clog2(COLS) | Column of the input byte |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Output frame byte |
| oh_sclk | output | 1 | Serial clock toward the source |
| oh_strobe | output | 1 | Request strobe, one serial period |
| oh_sdata | input | 1 | Serial overhead data from the source |

## Verification
The assertions check on every cycle the serial clock period and the strobe shape and alignment. They also check that bytes pass unchanged when the global switch is off or the column lies outside the overhead area. The bench's scenarios cover the rest. These are the bit order and slot mapping of substituted bytes, the commit at the frame boundary, the walking per-byte enables, the stalls under back-pressure, and the discarding of a capture that a position jump interrupts. All of these depend on a serial source model and on stream sequences over many frames.

// File: rtl/oh_ins_pkg.sv
package oh_ins_pkg;
  localparam int NBYTES  = 19;
  localparam int NBITS   = NBYTES * 8;
  localparam int OH_ROWS = 9;
  localparam int OH_COLS = 3;
  localparam int RW      = 4;
  localparam int BCW     = $clog2(NBITS);

  typedef enum logic [1:0] {CAP_IDLE, CAP_STROBE, CAP_SHIFT, CAP_DONE} cap_state_e;

  typedef struct packed {
    logic       hit;
    logic [4:0] idx;
  } oh_slot_t;

  function automatic oh_slot_t oh_slot(input logic [RW-1:0] row, input logic [1:0] col);
    oh_slot_t s;
    s = '0;
    case (row)
      4'd0: if (col == 2'd2) s = '{1'b1, 5'd0};
      4'd1: if (col != 2'd0) s = '{1'b1, 5'(col)};
      4'd2: s = '{1'b1, 5'd3 + 5'(col)};
      4'd4: if (col != 2'd0) s = '{1'b1, 5'd5 + 5'(col)};
      4'd5, 4'd6, 4'd7: s = '{1'b1, 5'd8 + 5'(row - 4'd5) * 5'd3 + 5'(col)};
      4'd8: if (col == 2'd0) s = '{1'b1, 5'd17};
            else if (col == 2'd2) s = '{1'b1, 5'd18};
      default: s = '0;
    endcase
    if (col == 2'd3) s = '0;
    return s;
  endfunction
endpackage

// File: rtl/oh_sclk_gen.sv
module oh_sclk_gen #(
  parameter int DIV = 360
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic tick
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (cnt == CW'(DIV - 1))  cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == CW'(DIV - 1));
  assign sclk = (cnt < CW'(HALF));
endmodule

// File: rtl/oh_pos_track.sv
module oh_pos_track import oh_ins_pkg::*; #(
  parameter int COLS = 90,
  localparam int CW  = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  output logic          fstart,
  output logic          jump
);
  logic [RW-1:0] exp_row;
  logic [CW-1:0] exp_col;
  logic          synced;

  assign fstart = beat && (row == '0) && (col == '0);
  assign jump   = beat && synced && ((row != exp_row) || (col != exp_col));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_row <= '0;
      exp_col <= '0;
      synced  <= 1'b0;
    end else if (beat) begin
      synced <= 1'b1;
      if (col == CW'(COLS - 1)) begin
        exp_col <= '0;
        exp_row <= (row == RW'(OH_ROWS - 1)) ? '0 : row + 1'b1;
      end else begin
        exp_col <= col + 1'b1;
        exp_row <= row;
      end
    end
  end
endmodule

// File: rtl/oh_capture.sv
module oh_capture import oh_ins_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sdata,
  input  logic             fstart,
  input  logic             jump,
  output logic             strobe,
  output logic             loaded,
  output logic [NBITS-1:0] active
);
  cap_state_e       st;
  logic             req;
  logic             abort_p;
  logic [BCW-1:0]   bitcnt;
  logic [NBITS-1:0] shadow;
  logic             busy;

  assign busy = (st == CAP_STROBE) || (st == CAP_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= CAP_IDLE;
      req     <= 1'b0;
      abort_p <= 1'b0;
      bitcnt  <= '0;
      shadow  <= '0;
      active  <= '0;
      loaded  <= 1'b0;
      strobe  <= 1'b0;
    end else begin
      if (jump && busy) abort_p <= 1'b1;
      if (fstart && (st == CAP_IDLE || abort_p || (jump && busy))) req <= 1'b1;
      if (st == CAP_DONE && fstart) begin
        active <= shadow;
        loaded <= 1'b1;
        req    <= 1'b1;
        st     <= CAP_IDLE;
      end
      if (tick) begin
        if (abort_p || (jump && busy)) begin
          st      <= CAP_IDLE;
          strobe  <= 1'b0;
          abort_p <= 1'b0;
        end else begin
          case (st)
            CAP_IDLE: if (req) begin
              st     <= CAP_STROBE;
              strobe <= 1'b1;
              req    <= 1'b0;
            end
            CAP_STROBE: begin
              st     <= CAP_SHIFT;
              strobe <= 1'b0;
              bitcnt <= '0;
            end
            CAP_SHIFT: begin
              shadow <= {shadow[NBITS-2:0], sdata};
              if (bitcnt == BCW'(NBITS - 1)) st <= CAP_DONE;
              else                           bitcnt <= bitcnt + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/oh_serial_insert.sv
module oh_serial_insert import oh_ins_pkg::*; #(
  parameter int DIV  = 360,
  parameter int COLS = 90,
  localparam int CW  = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_enable,
  input  logic [NBYTES-1:0] byte_enable,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic [RW-1:0]     s_row,
  input  logic [CW-1:0]     s_col,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_data,
  output logic              oh_sclk,
  output logic              oh_strobe,
  input  logic              oh_sdata
);
  logic             tick, beat, fstart, jump, loaded;
  logic [NBITS-1:0] active;
  oh_slot_t         slot;
  logic [7:0]       act_byte;

  assign beat    = s_valid && m_ready;
  assign m_valid = s_valid;
  assign s_ready = m_ready;

  oh_sclk_gen #(.DIV(DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .sclk(oh_sclk), .tick(tick)
  );

  oh_pos_track #(.COLS(COLS)) u_pos (
    .clk(clk), .rst_n(rst_n), .beat(beat), .row(s_row), .col(s_col),
    .fstart(fstart), .jump(jump)
  );

  oh_capture u_cap (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sdata(oh_sdata),
    .fstart(fstart), .jump(jump), .strobe(oh_strobe),
    .loaded(loaded), .active(active)
  );

  always_comb begin
    slot = (s_col < CW'(OH_COLS)) ? oh_slot(s_row, s_col[1:0]) : '0;
    act_byte = active[NBITS - 1 - 8 * int'(slot.idx) -: 8];
    if (ins_enable && loaded && slot.hit && byte_enable[slot.idx])
      m_data = act_byte;
    else
      m_data = s_data;
  end
endmodule

// File: rtl/oh_serial_insert_chk.sv
module oh_serial_insert_chk #(
  parameter int DIV = 360,
  parameter int CW  = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oh_sclk,
  input logic          oh_strobe,
  input logic          ins_enable,
  input logic [CW-1:0] s_col,
  input logic [7:0]    s_data,
  input logic [7:0]    m_data
);
  int   gap, hi;
  logic sclk_q, seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= 0; hi <= 0; sclk_q <= 1'b1; seen <= 1'b0;
    end else begin
      sclk_q <= oh_sclk;
      if (oh_sclk && !sclk_q) begin gap <= 1; seen <= 1'b1; end
      else                          gap <= gap + 1;
      hi <= oh_strobe ? hi + 1 : 0;
    end
  end

  a_r1_sclk_period: assert property (@(posedge clk) disable iff (!rst_n)
    (oh_sclk && !sclk_q && seen) |-> gap == DIV);

  a_r2_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oh_strobe) |-> $rose(oh_sclk));

  a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oh_strobe) |-> hi == DIV);

  a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_enable |-> m_data == s_data);

  a_r7_outside_cols: assert property (@(posedge clk) disable iff (!rst_n)
    (s_col >= CW'(3)) |-> m_data == s_data);
endmodule

bind oh_serial_insert oh_serial_insert_chk #(.DIV(DIV), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .oh_sclk(oh_sclk), .oh_strobe(oh_strobe),
  .ins_enable(ins_enable), .s_col(s_col), .s_data(s_data), .m_data(m_data)
);

// File: tb/oh_serial_insert_tb.sv
module oh_serial_insert_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int COLS = 12;
  localparam int CW   = $clog2(COLS);

  logic clk = 0, rst_n = 0;
  logic ins_enable = 0;
  logic [18:0] byte_enable = '0;
  logic s_valid = 0, m_ready = 1, oh_sdata = 0;
  logic [7:0] s_data = '0;
  logic [3:0] s_row = '0;
  logic [CW-1:0] s_col = '0;
  logic s_ready, m_valid, oh_sclk, oh_strobe;
  logic [7:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  oh_serial_insert #(.DIV(DIV), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ins_enable(ins_enable), .byte_enable(byte_enable),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_row(s_row), .s_col(s_col),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .oh_sclk(oh_sclk), .oh_strobe(oh_strobe), .oh_sdata(oh_sdata)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // linear position row*3+col of each slot, in arrival order (R3, R4)
  int slot_pos[19] = '{2, 4, 5, 6, 7, 8, 13, 14, 15, 16, 17, 18, 19, 20, 21, 22, 23, 24, 26};

  function automatic int find_slot(input int r, input int c);
    if (c > 2) return -1;
    for (int k = 0; k < 19; k++) if (slot_pos[k] == r * 3 + c) return k;
    return -1;
  endfunction

  function automatic logic [7:0] src_byte(input int req, input int k);
    return 8'((req * 53 + k * 29 + 1));
  endfunction

  // serial source model
  int req_id = 0, aborts = 0;
  logic [7:0] pend_bytes[19];
  bit pend = 0;

  initial begin
    bit seen = 0;
    bit done;
    int cur;
    wait (rst_n);
    forever begin
      if (!seen) begin
        @(posedge oh_sclk); #1;
        seen = oh_strobe;
      end else begin
        seen = 0; req_id++; cur = req_id; done = 1;
        for (int i = 0; i < 152; i++) begin
          @(posedge oh_sclk); #1;
          if (oh_strobe) begin aborts++; seen = 1; done = 0; break; end
          oh_sdata = src_byte(cur, i / 8)[7 - (i % 8)];
        end
        if (done) begin
          @(posedge oh_sclk); #1;
          for (int k = 0; k < 19; k++) pend_bytes[k] = src_byte(cur, k);
          pend = 1;
          seen = oh_strobe;
        end
      end
    end
  end

  // R1 / R2 timing monitors
  time last_rise = 0, fs_rise = 0;
  int  t_chk = 0;
  always @(posedge oh_sclk) last_rise = $time;
  always @(posedge oh_strobe) begin
    #1;
    fs_rise = $time - 1;
    if (t_chk < 6) begin
      chk(fs_rise == last_rise, "R2 strobe aligned to sclk rise", int'(fs_rise), int'(last_rise));
      t_chk++;
    end
  end
  always @(negedge oh_strobe) begin
    if (rst_n && t_chk < 12) begin
      chk(($time - fs_rise) == DIV * CLK_PERIOD, "R2 strobe width",
          int'($time - fs_rise), DIV * CLK_PERIOD);
      t_chk++;
    end
  end

  // stream model
  bit mloaded = 0;
  logic [7:0] mact[19];
  bit stall = 0;
  int stall_ctr = 0, commits = 0, commits_after_jump = 0, cur_frame = 0;

  task automatic send(input int r, input int c, input logic [7:0] d);
    int k;
    logic [7:0] exp;
    string tag;
    forever begin
      @(negedge clk);
      m_ready = stall ? ((stall_ctr % 3) != 0) : 1'b1;
      stall_ctr++;
      s_valid = 1; s_row = 4'(r); s_col = CW'(c); s_data = d;
      #1;
      chk(m_valid == 1'b1, "R9 m_valid follows s_valid", m_valid, 1);
      chk(s_ready == m_ready, "R9 s_ready follows m_ready", s_ready, m_ready);
      k = find_slot(r, c);
      if (k >= 0 && ins_enable && mloaded && byte_enable[k]) begin
        exp = mact[k]; tag = "R3 substituted slot byte";
      end else begin
        exp = d;
        tag = (k >= 0) ? "R6 slot passthrough" : "R7 non-slot passthrough";
      end
      chk(m_data == exp, tag, m_data, exp);
      if (m_ready) begin
        if (r == 0 && c == 0 && pend) begin
          for (int j = 0; j < 19; j++) mact[j] = pend_bytes[j];
          mloaded = 1; pend = 0; commits++;
          if (cur_frame >= 33) commits_after_jump++;
        end
        break;
      end
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  // R1 serial clock shape
  initial begin
    time t0, t1, t2;
    wait (rst_n);
    @(posedge oh_sclk); t0 = $time;
    @(negedge oh_sclk); t2 = $time;
    @(posedge oh_sclk); t1 = $time;
    chk((t1 - t0) == DIV * CLK_PERIOD, "R1 sclk period", int'(t1 - t0), DIV * CLK_PERIOD);
    chk((t2 - t0) == (DIV / 2) * CLK_PERIOD, "R1 sclk high time", int'(t2 - t0), (DIV / 2) * CLK_PERIOD);
  end

  initial begin
    int nb;
    // R10 reset state
    ins_enable = 1; byte_enable = '1;
    s_valid = 1; s_row = 0; s_col = CW'(2); s_data = 8'h3C;
    repeat (3) @(negedge clk);
    chk(oh_strobe == 1'b0, "R10 strobe low in reset", oh_strobe, 0);
    chk(m_data == 8'h3C, "R10 passthrough in reset", m_data, 8'h3C);
    s_valid = 0;
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    chk(m_data == 8'h3C, "R10 passthrough before first set", m_data, 8'h3C);
    chk(oh_strobe == 1'b0, "R2 no strobe before a frame start", oh_strobe, 0);

    for (int f = 0; f < 46; f++) begin
      cur_frame = f;
      stall = 0; ins_enable = 1; byte_enable = '1; nb = 9 * COLS;
      if (f >= 6 && f < 25) byte_enable = 19'(1) << (f - 6);     // R6 walking enable
      else if (f == 25) begin byte_enable = 19'h55555; stall = 1; end
      else if (f == 26) begin byte_enable = 19'h2AAAA; stall = 1; end
      else if (f == 27) stall = 1;
      else if (f == 28) ins_enable = 0;                           // R6 global off
      else if (f >= 29 && f < 33) nb = 40;                        // R8 jumps
      for (int n = 0; n < nb; n++)
        send(n / COLS, n % COLS, 8'((n / COLS) * 31 + (n % COLS) * 7 + f));
    end
    @(negedge clk); s_valid = 0;
    chk(m_valid == 1'b0, "R9 m_valid low when idle", m_valid, 0);
    chk(commits >= 2, "R5 sets committed at frame starts", commits, 2);
    chk(aborts >= 1, "R8 capture abandoned on jump", aborts, 1);
    chk(commits_after_jump >= 1, "R8 fresh request after jump committed", commits_after_jump, 1);
    finish_run();
  end
endmodule